// File: doc/BRIEF.md
# UART Interrupt Source Prioritiser and Identifier

This block gathers the five interrupt causes of a serial port into one request line and an 8-bit identification value that software reads to find out which cause to service first. Each cause is held in its own pending flag. A flag is set by an event from the receiver, the transmitter or the modem-line logic. It is cleared by the register access that services that cause. The flags, the sources that feed them and the registers are all outside this block; here they appear only as event inputs and access strobes.

An enable mask decides which pending flags take part. A fixed priority encoder picks the most urgent enabled cause and writes its code into the identification value. The request pin is driven only while the modem-control output-enable bit is set. The identification value and the request are both registered, so both can be read straight from flops.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable bit 2 admits the line-status cause, bit 0 admits both received-data and timeout, bit 1 admits holding-empty, and bit 3 admits modem-status. Enable bits 7 to 4 have no effect. A masked cause keeps its pending flag and shows up once it is unmasked.
- R2: When several enabled causes are pending, the one reported in identification bits 3:1 is chosen by this fixed order: line status first with code 3'b011, then received data with 3'b010, then timeout with 3'b100, then holding-empty with 3'b001, and modem status last with 3'b000.
- R3: Identification bit 0 is 0 while any enabled cause is pending. When no enabled cause is pending, bit 0 is 1 and bits 3:1 read 3'b000. After reset the value is 8'h01.
- R4: Identification bits 7:6 read 2'b11 when the FIFO-mode input is 1 and 2'b00 when it is 0. Bits 5:4 always read 0.
- R5: A line-status-register read strobe clears the line-status cause.
- R6: A receive-data read strobe clears both the received-data cause and the timeout cause.
- R7: A modem-status read strobe clears the modem-status cause.
- R8: The holding-empty cause is cleared by a transmit-data write strobe. It is also cleared by an identification read strobe, but only when the identification value at that read reports holding-empty; an identification read has no effect while another cause is reported.
- R9: The holding-empty cause is set when the holding-empty status input rises. It is also set when enable bit 1 goes from 0 to 1 while that status is already 1.
- R10: Timeout events are accepted only in FIFO mode. When FIFO mode is turned off, any pending timeout cause is dropped.
- R11: The request output is 1 only when the output-enable input is 1 and at least one enabled cause is pending.
- R12: If an event and the strobe that clears it arrive in the same cycle, the cause stays pending. The identification value and the request reflect an event or strobe two clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ena_mask | input | 8 | Interrupt enable mask value |
| fifo_on | input | 1 | FIFO mode active |
| out_en | input | 1 | Modem-control output enable that gates the request pin |
| ev_line_err | input | 1 | Receiver line-status error event |
| ev_rx_data | input | 1 | Received data available event |
| ev_rx_tmo | input | 1 | Character timeout event |
| thr_empty | input | 1 | Holding register empty status (level) |
| ev_modem | input | 1 | Modem-status change event |
| rd_lsr | input | 1 | Line-status register read strobe |
| rd_rbr | input | 1 | Receive data register read strobe |
| rd_msr | input | 1 | Modem-status register read strobe |
| rd_iid | input | 1 | Identification register read strobe |
| wr_thr | input | 1 | Transmit data register write strobe |
| iid | output | 8 | Registered identification value |
| irq | output | 1 | Registered interrupt request |

## Verification
An event, strobe, mask change or mode change is sampled at one clock edge and updates a pending flag there. The registered identification value and request follow at the next edge, so every result is due two edges after its stimulus. The bench drives all inputs on the falling edge, holds a pulse for exactly one rising edge, waits one more rising edge, and samples on the following falling edge. An identification read is issued while the value it is meant to clear is already showing on the port, and the effect is checked two edges later. This is what exercises the rule that only the reported holding-empty cause is cleared.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 5;
  localparam int CODE_W = 3;

  // rank 0 is the highest priority
  localparam int RK_LS = 0;
  localparam int RK_RD = 1;
  localparam int RK_TO = 2;
  localparam int RK_TH = 3;
  localparam int RK_MS = 4;

  function automatic logic [CODE_W-1:0] rank_code(input int rk);
    case (rk)
      RK_LS:   return 3'b011;
      RK_RD:   return 3'b010;
      RK_TO:   return 3'b100;
      RK_TH:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/uirq_flag.sv
module uirq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q); // R12
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q); // R5
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]      pend,
  output logic [CODE_W-1:0] code,
  output logic              any
);
  always_comb begin
    code = '0;
    any  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        code = rank_code(i);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
#(
  parameter int IER_W = 8,
  parameter int IID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IER_W-1:0] ena_mask,
  input  logic             fifo_on,
  input  logic             out_en,
  input  logic             ev_line_err,
  input  logic             ev_rx_data,
  input  logic             ev_rx_tmo,
  input  logic             thr_empty,
  input  logic             ev_modem,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_msr,
  input  logic             rd_iid,
  input  logic             wr_thr,
  output logic [IID_W-1:0] iid,
  output logic             irq
);
  localparam int CODE_LO = 1;
  localparam int CODE_HI = CODE_LO + CODE_W - 1;
  localparam int PAD_W   = IID_W - CODE_W - 3;

  logic [NSRC-1:0]   set_v, clr_v, flag_v, en_v, pend_v;
  logic              thr_d, th_en_d;
  logic [CODE_W-1:0] top_code;
  logic              top_any;
  logic              iid_shows_th;

  // edge detectors for holding-empty re-arm
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_d   <= 1'b0;
      th_en_d <= 1'b0;
    end else begin
      thr_d   <= thr_empty;
      th_en_d <= ena_mask[1];
    end
  end

  assign iid_shows_th = !iid[0] && (iid[CODE_HI:CODE_LO] == rank_code(RK_TH));

  always_comb begin
    set_v        = '0;
    clr_v        = '0;
    set_v[RK_LS] = ev_line_err;
    clr_v[RK_LS] = rd_lsr;
    set_v[RK_RD] = ev_rx_data;
    clr_v[RK_RD] = rd_rbr;
    set_v[RK_TO] = ev_rx_tmo && fifo_on;
    clr_v[RK_TO] = rd_rbr || !fifo_on;
    set_v[RK_TH] = (thr_empty && !thr_d) || (thr_empty && ena_mask[1] && !th_en_d);
    clr_v[RK_TH] = wr_thr || (rd_iid && iid_shows_th);
    set_v[RK_MS] = ev_modem;
    clr_v[RK_MS] = rd_msr;
  end

  always_comb begin
    en_v        = '0;
    en_v[RK_LS] = ena_mask[2];
    en_v[RK_RD] = ena_mask[0];
    en_v[RK_TO] = ena_mask[0];
    en_v[RK_TH] = ena_mask[1];
    en_v[RK_MS] = ena_mask[3];
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      uirq_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v[g]),
        .clr_i (clr_v[g]),
        .q     (flag_v[g])
      );
    end
  endgenerate

  assign pend_v = flag_v & en_v;

  uirq_prio #(.N(NSRC)) u_prio (
    .pend (pend_v),
    .code (top_code),
    .any  (top_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iid <= {{(IID_W-1){1'b0}}, 1'b1};
      irq <= 1'b0;
    end else begin
      iid <= {{2{fifo_on}}, {PAD_W{1'b0}}, top_code, !top_any};
      irq <= out_en && top_any;
    end
  end

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !irq); // R11
  AST_PEND_LOW: assert property (@(posedge clk) disable iff (rst)
    irq |-> !iid[0]); // R3
  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (rst)
    fifo_on |=> (iid[IID_W-1:IID_W-2] == 2'b11)); // R4
  AST_TMO_FIFO: assert property (@(posedge clk) disable iff (rst)
    !fifo_on |=> !flag_v[RK_TO]); // R10
  AST_THR_WR: assert property (@(posedge clk) disable iff (rst)
    (wr_thr && !set_v[RK_TH]) |=> !flag_v[RK_TH]); // R8
  AST_RBR_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd_rbr && !ev_rx_data) |=> !flag_v[RK_RD]); // R6
endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ena_mask = 8'h00;
  logic       fifo_on = 1'b0, out_en = 1'b0;
  logic       ev_line_err = 0, ev_rx_data = 0, ev_rx_tmo = 0, thr_empty = 0, ev_modem = 0;
  logic       rd_lsr = 0, rd_rbr = 0, rd_msr = 0, rd_iid = 0, wr_thr = 0;
  logic [7:0] iid;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst(rst), .ena_mask(ena_mask), .fifo_on(fifo_on), .out_en(out_en),
    .ev_line_err(ev_line_err), .ev_rx_data(ev_rx_data), .ev_rx_tmo(ev_rx_tmo),
    .thr_empty(thr_empty), .ev_modem(ev_modem), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
    .rd_msr(rd_msr), .rd_iid(rd_iid), .wr_thr(wr_thr), .iid(iid), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one-cycle strobe/event; flag at first edge, outputs at second edge
  task automatic pulse(input int which);
    case (which)
      0: ev_line_err = 1; 1: ev_rx_data = 1; 2: ev_rx_tmo = 1; 3: ev_modem = 1;
      4: rd_lsr = 1; 5: rd_rbr = 1; 6: rd_msr = 1; 7: rd_iid = 1; default: wr_thr = 1;
    endcase
    @(negedge clk);
    {ev_line_err, ev_rx_data, ev_rx_tmo, ev_modem} = '0;
    {rd_lsr, rd_rbr, rd_msr, rd_iid, wr_thr} = '0;
    step(1);
  endtask

  task automatic clear_all();
    {rd_lsr, rd_rbr, rd_msr, wr_thr} = 4'hF;
    @(negedge clk);
    {rd_lsr, rd_rbr, rd_msr, wr_thr} = '0;
    step(1);
  endtask

  task automatic t_reset();
    chk("R3 reset iid", iid, 8'h01);
    chk("R11 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_priority();
    ena_mask = 8'h0F; fifo_on = 1; out_en = 1; step(2);
    chk("R4 fifo bits idle", iid, 8'hC1);
    pulse(3); chk("R2 modem code", iid, 8'hC0);
    chk("R11 irq on", {7'b0, irq}, 8'h01);
    pulse(0); chk("R2 line status wins", iid, 8'hC6);
    pulse(1); pulse(2); chk("R2 line status over data", iid, 8'hC6);
    pulse(4); chk("R5 lsr read -> data", iid, 8'hC4);
    pulse(5); chk("R6 rbr read clears data and timeout", iid, 8'hC0);
    pulse(6); chk("R7 msr read clears modem", iid, 8'hC1);
    chk("R11 irq off", {7'b0, irq}, 8'h00);
    pulse(2); chk("R2 timeout code", iid, 8'hC8);
    pulse(3); chk("R2 timeout over modem", iid, 8'hC8);
    pulse(5); chk("R6 rbr clears timeout", iid, 8'hC0);
    clear_all(); chk("R3 all clear", iid, 8'hC1);
  endtask

  task automatic t_thre();
    thr_empty = 1; step(2); chk("R9 rise sets thre", iid, 8'hC2);
    pulse(7); chk("R8 iid read clears reported thre", iid, 8'hC1);
    thr_empty = 0; step(1); thr_empty = 1; step(2);
    chk("R9 second rise", iid, 8'hC2);
    pulse(8); chk("R8 thr write clears", iid, 8'hC1);
    ena_mask = 8'h0D; step(2); ena_mask = 8'h0F; step(2);
    chk("R9 enable rearm", iid, 8'hC2);
    pulse(0); chk("R2 line over thre", iid, 8'hC6);
    pulse(7); pulse(4);
    chk("R8 iid read kept unreported thre", iid, 8'hC2);
    pulse(8); thr_empty = 0; step(1);
    chk("R8 cleared", iid, 8'hC1);
  endtask

  task automatic t_mask();
    ena_mask = 8'hF0; pulse(0);
    chk("R1 upper bits ignored", iid, 8'hC1);
    chk("R1 irq masked", {7'b0, irq}, 8'h00);
    ena_mask = 8'h04; step(2); chk("R1 unmask line status", iid, 8'hC6);
    pulse(1); ena_mask = 8'h01; step(2); chk("R1 bit0 data only", iid, 8'hC4);
    ena_mask = 8'h0F; clear_all(); chk("R1 cleared", iid, 8'hC1);
  endtask

  task automatic t_fifo();
    fifo_on = 0; step(2); chk("R4 non-fifo idle", iid, 8'h01);
    pulse(2); chk("R10 timeout ignored", iid, 8'h01);
    pulse(1); chk("R4 data non-fifo", iid, 8'h04);
    pulse(5); fifo_on = 1; step(2);
    pulse(2); chk("R10 timeout in fifo", iid, 8'hC8);
    fifo_on = 0; step(2); chk("R10 leaving fifo drops timeout", iid, 8'h01);
    fifo_on = 1; step(2);
  endtask

  task automatic t_gate_and_race();
    out_en = 0; pulse(3);
    chk("R11 gated irq", {7'b0, irq}, 8'h00);
    chk("R11 iid still reports", iid, 8'hC0);
    out_en = 1; step(2); chk("R11 irq enabled", {7'b0, irq}, 8'h01);
    pulse(6);
    ev_line_err = 1; rd_lsr = 1; @(negedge clk);
    ev_line_err = 0; rd_lsr = 0; step(1);
    chk("R12 set beats clear", iid, 8'hC6);
    clear_all();
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    t_reset();
    t_priority();
    t_thre();
    t_mask();
    t_fifo();
    t_gate_and_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule